// File: doc/BRIEF.md
# Multi-Rate Clock Fan-Out Bank

This block turns one master clock into a bank of fourteen output clock lanes. The master clock runs at four times the system frequency Q. Each lane carries one of three rates: twice Q, Q, or half Q. A 3-bit option code decides how many lanes run at each rate. Lanes are filled in ascending index order, fastest rate first. Every rate comes from the inverted bits of one 4-bit counter. Because of that, all lanes and the feedback clock rise together whenever the lower counter bits return to zero, and every output has an exact 50% duty cycle.

A separate feedback output runs at Q/4, Q/2 or Q. A 2-bit multiplication code picks its rate. This output is never disabled, so a surrounding loop stays locked while the lanes are switched off. An active-high lane enable drives a pad output-enable. While the lane enable is low, the lanes are quiet. When it returns high, the lanes wait for the next common rising edge before they run again, so they come back with correct phase within two Q cycles. A bypass input routes a reference clock straight to the lanes and to the feedback output.

Both codes are captured only on the master-counter wrap. A change of code therefore never cuts a clock pulse short.

Top module: `clk_fanout_bank`

## Requirements
- R1: While `rst_n` is low, the counter is held at zero. All lanes are driven low, `fb_clk` is high and `lane_oe` equals `lane_en`.
- R2: With bypass off and lanes running, a twice-Q lane toggles on every master clock, a Q lane every 2 clocks and a half-Q lane every 4 clocks. Each lane is high for half its period, and all lanes rise on the same master edge.
- R3: Option codes set the lane split as follows: 000 gives 2 twice-Q lanes and 12 Q lanes; 001 gives 2 twice-Q, 4 Q and 8 half-Q lanes; 010 gives 4 twice-Q and 10 Q lanes; 011 gives 14 Q lanes; 100 gives 7 Q and 7 half-Q lanes; 111 gives 2 twice-Q and 12 Q lanes. Lane 0 upward takes the faster rates first.
- R4: Option codes 101 and 110 give the same split as code 000.
- R5: `fb_clk` runs at Q/4 for multiplication code 00, at Q/2 for 01 and at Q for 11. Code 10 gives Q/4.
- R6: New option and multiplication codes are captured only on the edge where the 4-bit master counter wraps from 15 to 0. A change made at any other time leaves the outputs on the old codes until that edge.
- R7: While `lane_en` is low, `lane_oe` is low at once. From the next master edge the lanes are driven low. `fb_clk` keeps toggling.
- R8: After `lane_en` returns high, the lanes stay low until the low three counter bits are zero. The lanes then restart with all of them high together. This wait is at most 8 master clocks.
- R9: While `pll_bypass` is high, `fb_clk` equals `ref_clk`. Every lane equals `ref_clk` while `lane_en` is high and is low while `lane_en` is low. There is no register delay in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_4x | input | 1 | Master clock at four times Q |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_en | input | 1 | Active-high lane enable; low turns off the lane pads |
| pll_bypass | input | 1 | Routes `ref_clk` directly to the lanes and the feedback output |
| ref_clk | input | 1 | Reference clock used in bypass |
| opt_code | input | 3 | Lane rate split selector |
| mult_code | input | 2 | Feedback rate selector |
| lane_clk | output | 14 | Output clock lanes |
| lane_oe | output | 1 | Pad output-enable for all lanes |
| fb_clk | output | 1 | Feedback clock, never disabled |

## Verification
A wrong counter value shows up as a lane or `fb_clk` level that differs from the expected waveform on the very next master clock, because every output is a direct function of the counter. A stale or wrongly latched code shows up at the first wrap edge after a code change: a lane then runs at the wrong rate. A wrong enable-wait flag shows up as lanes that restart on a non-aligned edge or stay low longer than 8 clocks. All of these faults appear within at most 16 master clocks. That is why the bench compares every output on every cycle against its own counter model.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

    localparam int PHASE_N = 4;

    // The rate code doubles as the index of the counter bit that produces it.
    typedef enum logic [1:0] {
        RATE_2XQ      = 2'd0,
        RATE_Q        = 2'd1,
        RATE_HALFQ    = 2'd2,
        RATE_QUARTERQ = 2'd3
    } rate_e;

    typedef struct packed {
        logic [4:0] n_fast;
        logic [4:0] n_sys;
    } split_t;

    typedef struct packed {
        logic [PHASE_N-1:0] cnt;
        logic               live;
        logic [2:0]         opt;
        logic [1:0]         mult;
    } bank_state_t;

    // Lane split per option code; unlisted codes use the 000 split.
    function automatic split_t lane_split(input logic [2:0] opt);
        split_t s;
        case (opt)
            3'b001:  begin s.n_fast = 5'd2; s.n_sys = 5'd4;  end
            3'b010:  begin s.n_fast = 5'd4; s.n_sys = 5'd10; end
            3'b011:  begin s.n_fast = 5'd0; s.n_sys = 5'd14; end
            3'b100:  begin s.n_fast = 5'd0; s.n_sys = 5'd7;  end
            default: begin s.n_fast = 5'd2; s.n_sys = 5'd12; end
        endcase
        return s;
    endfunction

    function automatic rate_e fb_rate_of(input logic [1:0] mult);
        case (mult)
            2'b01:   return RATE_HALFQ;
            2'b11:   return RATE_Q;
            default: return RATE_QUARTERQ;
        endcase
    endfunction

endpackage

// File: rtl/clkbank_cfg_decode.sv
module clkbank_cfg_decode
    import clkbank_pkg::*;
#(
    parameter int NUM_LANES = 14
) (
    input  logic [2:0]                opt_i,
    input  logic [1:0]                mult_i,
    output rate_e [NUM_LANES-1:0]     lane_rate_o,
    output rate_e                     fb_rate_o
);

    split_t split;
    int     fast_end;
    int     sys_end;

    always_comb begin
        split    = lane_split(opt_i);
        fast_end = int'(split.n_fast);
        sys_end  = int'(split.n_fast) + int'(split.n_sys);
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign lane_rate_o[i] = (i < fast_end) ? RATE_2XQ :
                                (i < sys_end)  ? RATE_Q   : RATE_HALFQ;
    end

    assign fb_rate_o = fb_rate_of(mult_i);

endmodule

// File: rtl/clkbank_lane_mux.sv
module clkbank_lane_mux
    import clkbank_pkg::*;
#(
    parameter int NUM_LANES = 14
) (
    input  logic [PHASE_N-1:0]        phase_i,
    input  rate_e [NUM_LANES-1:0]     lane_rate_i,
    input  logic                      live_i,
    input  logic                      bypass_i,
    input  logic                      en_i,
    input  logic                      ref_i,
    output logic [NUM_LANES-1:0]      lane_o
);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign lane_o[i] = bypass_i ? (en_i & ref_i)
                                    : (live_i & phase_i[lane_rate_i[i]]);
    end

endmodule

// File: rtl/clk_fanout_bank.sv
module clk_fanout_bank
    import clkbank_pkg::*;
#(
    parameter int NUM_LANES = 14
) (
    input  logic                 clk_4x,
    input  logic                 rst_n,
    input  logic                 lane_en,
    input  logic                 pll_bypass,
    input  logic                 ref_clk,
    input  logic [2:0]           opt_code,
    input  logic [1:0]           mult_code,
    output logic [NUM_LANES-1:0] lane_clk,
    output logic                 lane_oe,
    output logic                 fb_clk
);

    localparam int                 CNT_W     = PHASE_N;
    localparam logic [CNT_W-1:0]   CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0]   CNT_WRAP  = '1;
    localparam logic [2:0]         HALF_WRAP = 3'b111;

    bank_state_t st_d;
    bank_state_t st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_ONE;
        if (!lane_en) begin
            st_d.live = 1'b0;
        end else if (st_q.cnt[2:0] == HALF_WRAP) begin
            st_d.live = 1'b1;
        end
        if (st_q.cnt == CNT_WRAP) begin
            st_d.opt  = opt_code;
            st_d.mult = mult_code;
        end
    end

    always_ff @(posedge clk_4x) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, live: 1'b0, opt: opt_code, mult: mult_code};
        end else begin
            st_q <= st_d;
        end
    end

    // Inverted counter bits: every phase rises when the lower bits wrap.
    logic [CNT_W-1:0]       phase;
    rate_e [NUM_LANES-1:0]  lane_rate;
    rate_e                  fb_rate;

    assign phase = ~st_q.cnt;

    clkbank_cfg_decode #(.NUM_LANES(NUM_LANES)) u_decode (
        .opt_i       (st_q.opt),
        .mult_i      (st_q.mult),
        .lane_rate_o (lane_rate),
        .fb_rate_o   (fb_rate)
    );

    clkbank_lane_mux #(.NUM_LANES(NUM_LANES)) u_mux (
        .phase_i     (phase),
        .lane_rate_i (lane_rate),
        .live_i      (st_q.live),
        .bypass_i    (pll_bypass),
        .en_i        (lane_en),
        .ref_i       (ref_clk),
        .lane_o      (lane_clk)
    );

    assign fb_clk  = pll_bypass ? ref_clk : phase[fb_rate];
    assign lane_oe = lane_en;

endmodule

// File: rtl/clk_fanout_bank_chk.sv
module clk_fanout_bank_chk #(
    parameter int NUM_LANES = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lane_en,
    input logic                 pll_bypass,
    input logic                 ref_clk,
    input logic [NUM_LANES-1:0] lane_clk,
    input logic                 fb_clk,
    input logic [3:0]           cnt,
    input logic                 live,
    input logic [2:0]           opt,
    input logic [1:0]           mult
);

    a_r2_fast_lane_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_bypass && $past(!pll_bypass) && live && $past(live) &&
         opt != 3'b011 && opt != 3'b100 && opt == $past(opt))
        |-> lane_clk[0] != $past(lane_clk[0]));

    a_r3_all_q_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_bypass && live && opt == 3'b011)
        |-> (lane_clk == '0 || lane_clk == '1));

    a_r5_quarter_fb_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_bypass && $past(!pll_bypass) && (mult == 2'b00 || mult == 2'b10) &&
         mult == $past(mult) && fb_clk != $past(fb_clk))
        |-> cnt[2:0] == 3'b000);

    a_r6_cfg_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ({opt, mult} != $past({opt, mult})))
        |-> cnt == 4'd0);

    a_r7_lanes_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!lane_en && !pll_bypass)
        |=> (pll_bypass || lane_clk == '0));

    a_r8_release_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(live) |-> cnt[2:0] == 3'b000);

    a_r9_bypass_follows_ref: assert property (@(posedge clk) disable iff (!rst_n)
        pll_bypass |-> (fb_clk == ref_clk &&
                        lane_clk == (lane_en ? {NUM_LANES{ref_clk}} : {NUM_LANES{1'b0}})));

endmodule

bind clk_fanout_bank clk_fanout_bank_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk        (clk_4x),
    .rst_n      (rst_n),
    .lane_en    (lane_en),
    .pll_bypass (pll_bypass),
    .ref_clk    (ref_clk),
    .lane_clk   (lane_clk),
    .fb_clk     (fb_clk),
    .cnt        (st_q.cnt),
    .live       (st_q.live),
    .opt        (st_q.opt),
    .mult       (st_q.mult)
);

// File: tb/clk_fanout_bank_bench.sv
`timescale 1ns/1ps
module clk_fanout_bank_bench;

    localparam int NL = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lane_en = 1'b1;
    logic          pll_bypass = 1'b0;
    logic          ref_clk = 1'b0;
    logic [2:0]    opt_code = 3'b000;
    logic [1:0]    mult_code = 2'b00;
    logic [NL-1:0] lane_clk;
    logic          lane_oe;
    logic          fb_clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    clk_fanout_bank #(.NUM_LANES(NL)) u_clk_fanout_bank (
        .clk_4x(clk), .rst_n(rst_n), .lane_en(lane_en), .pll_bypass(pll_bypass),
        .ref_clk(ref_clk), .opt_code(opt_code), .mult_code(mult_code),
        .lane_clk(lane_clk), .lane_oe(lane_oe), .fb_clk(fb_clk));

    // Reference model built from the requirements.
    logic [3:0] m_cnt;
    logic       m_live;
    logic [2:0] m_opt;
    logic [1:0] m_mult;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 4'd0; m_live <= 1'b0; m_opt <= opt_code; m_mult <= mult_code;
        end else begin
            m_cnt  <= m_cnt + 4'd1;
            m_live <= lane_en && (m_live || m_cnt[2:0] == 3'b111);
            if (m_cnt == 4'd15) begin
                m_opt <= opt_code; m_mult <= mult_code;
            end
        end
    end

    function automatic int exp_rate(input logic [2:0] opt, input int lane);
        int nf, ns;
        case (opt)
            3'b001:  begin nf = 2; ns = 4;  end
            3'b010:  begin nf = 4; ns = 10; end
            3'b011:  begin nf = 0; ns = 14; end
            3'b100:  begin nf = 0; ns = 7;  end
            default: begin nf = 2; ns = 12; end
        endcase
        if (lane < nf) return 0;
        if (lane < nf + ns) return 1;
        return 2;
    endfunction

    function automatic int exp_fb_bit(input logic [1:0] m);
        case (m)
            2'b01:   return 2;
            2'b11:   return 1;
            default: return 3;
        endcase
    endfunction

    function automatic logic [NL-1:0] exp_lanes();
        logic [NL-1:0] v;
        for (int i = 0; i < NL; i++) begin
            if (pll_bypass) v[i] = lane_en & ref_clk;
            else            v[i] = m_live & ~m_cnt[exp_rate(m_opt, i)];
        end
        return v;
    endfunction

    task automatic check_now(input string tag);
        logic [NL-1:0] el;
        logic ef;
        el = exp_lanes();
        ef = pll_bypass ? ref_clk : ~m_cnt[exp_fb_bit(m_mult)];
        n_checks++;
        if (lane_clk !== el || fb_clk !== ef || lane_oe !== lane_en) begin
            n_fail++;
            $display("FAIL %s lanes=%b exp=%b fb=%b exp=%b oe=%b exp=%b",
                     tag, lane_clk, el, fb_clk, ef, lane_oe, lane_en);
        end
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        check_now(tag);
    endtask

    task automatic expect_int(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int wait_n, hi0, hi13, fb_tog;
        logic fb_prev;
        void'($urandom(32'd1234));

        // R1: reset state
        repeat (3) @(negedge clk);
        n_checks++;
        if (lane_clk !== '0 || fb_clk !== 1'b1 || lane_oe !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 lanes=%b exp=0 fb=%b exp=1 oe=%b exp=1", lane_clk, fb_clk, lane_oe);
        end
        check_now("R1");

        // R2: base code, duty and phase
        rst_n = 1'b1;
        repeat (16) tick("R2");
        hi0 = 0; hi13 = 0;
        for (int k = 0; k < 32; k++) begin
            tick("R2");
            hi0 += int'(lane_clk[0]); hi13 += int'(lane_clk[13]);
        end
        expect_int("R2 fast-lane duty", hi0, 16);
        expect_int("R2 q-lane duty", hi13, 16);

        // R3/R4: every option code
        for (int c = 0; c < 8; c++) begin
            opt_code = 3'(c);
            repeat (40) tick((c == 5 || c == 6) ? "R4" : "R3");
        end

        // R6: change away from the wrap point; outputs keep old split
        while (m_cnt != 4'd3) @(negedge clk);
        opt_code = 3'b011;
        tick("R6");
        expect_int("R6 code still old", int'(m_opt), 7);
        repeat (20) tick("R6");

        // R5: feedback rates
        for (int m = 0; m < 4; m++) begin
            mult_code = 2'(m);
            repeat (48) tick("R5");
        end

        // R7: lanes off, feedback still runs
        opt_code = 3'b001;
        repeat (20) tick("R7");
        lane_en = 1'b0;
        fb_tog = 0; fb_prev = fb_clk;
        for (int k = 0; k < 24; k++) begin
            tick("R7");
            if (fb_clk != fb_prev) fb_tog++;
            fb_prev = fb_clk;
        end
        n_checks++;
        if (fb_tog == 0) begin
            n_fail++;
            $display("FAIL R7 fb toggles=%0d exp>0", fb_tog);
        end

        // R8: release at an unaligned point
        while (m_cnt[2:0] != 3'd2) @(negedge clk);
        lane_en = 1'b1;
        wait_n = 0;
        do begin
            tick("R8");
            wait_n++;
        end while (lane_clk == '0 && wait_n < 20);
        n_checks++;
        if (wait_n > 8 || lane_clk !== '1) begin
            n_fail++;
            $display("FAIL R8 wait=%0d exp<=8 lanes=%b exp=all ones", wait_n, lane_clk);
        end
        repeat (16) tick("R8");

        // R9: bypass with lanes on and off
        pll_bypass = 1'b1;
        for (int k = 0; k < 12; k++) begin
            ref_clk = ~ref_clk;
            if (k == 6) lane_en = 1'b0;
            tick("R9");
        end
        lane_en = 1'b1; pll_bypass = 1'b0; ref_clk = 1'b0;

        // Random mix
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 15) == 0) opt_code  = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 15) == 0) mult_code = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 31) == 0) lane_en   = ~lane_en;
            if ($urandom_range(0, 63) == 0) pll_bypass = ~pll_bypass;
            ref_clk = 1'($urandom_range(0, 1));
            tick("R2");
        end

        finish_run();
    end

endmodule